// File: doc/BRIEF.md
# Multiword DMA Host Sequencer

This block is the host-side engine for mode 0 multiword DMA on a 16-bit parallel disk interface. The device raises its request line. The sequencer then asserts the active-low acknowledge and issues a train of read or write strobes, one 16-bit word per strobe. It keeps the train going for as long as the device keeps requesting and the local side can supply or absorb words. When the train ends, it releases the acknowledge only after the required hold time.

All bus timing is derived from a system clock. Every nanosecond limit is a parameter and is converted to a cycle count by rounding up, with a floor of one cycle for any non-zero minimum. On the local side, words are taken from a transmit FIFO (valid/pop) for writes and handed to a receive FIFO (push/full) for reads. A level input from the local controller asks the sequencer to end the transfer. The figures below assume the default parameters and a 4 ns clock.

Top module: `atadma_host`

## Requirements
- R1: After reset, `dmack_n`, `dior_n` and `diow_n` are high and `dd_oe` is low.
- R2: Each strobe (`dior_n` or `diow_n`) is held low for exactly 54 cycles, which is at least 215 ns.
- R3: Within one burst, successive strobe leading edges are exactly 120 cycles apart, which is at least 480 ns.
- R4: Between strobes of one burst, the strobe stays high for 66 cycles. This covers the separate minimum high widths for reads (13 cycles) and writes (54 cycles), stretched to meet the cycle time.
- R5: `dmack_n` goes low exactly one cycle before the first strobe of a burst and stays low while any strobe is low.
- R6: After the last strobe of a burst, `dmack_n` rises exactly 30 cycles after a read trailing edge or 10 cycles after a write trailing edge. Both are at least the 5-cycle acknowledge hold.
- R7: On writes, `dd_out` holds the next transmit word, unchanged, throughout each `diow_n` low phase. The words appear in FIFO order. `dd_oe` stays high for at least 5 cycles after every write trailing edge.
- R8: On reads, the value on `dd_in` at the `dior_n` trailing edge is delivered on `rx_data` with a one-cycle `rx_push` pulse.
- R9: The request line is examined only at 30 cycles (read) or 10 cycles (write) after a trailing edge. A drop of `dmarq` that ends before that point does not end the burst. `dmarq` low at that point ends the burst.
- R10: At the same decision point, a high `term_cnt`, an empty transmit FIFO (on writes) or a full receive FIFO (on reads) ends the burst.
- R11: `dd_oe` is high only from the start of a write burst until its acknowledge is released. It is never high during a read strobe, and the two strobes are never low together.
- R12: No burst starts while `dmarq` is low, while `term_cnt` is high, or while the FIFO for the selected direction (`dir_wr` = 1 for write) cannot serve a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dmarq | input | 1 | Device DMA request |
| dir_wr | input | 1 | Direction for the next burst: 1 = write to device, 0 = read |
| term_cnt | input | 1 | Local request to end the transfer |
| tx_data | input | 16 | Head word of the transmit FIFO |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_pop | output | 1 | Takes the head word of the transmit FIFO |
| rx_data | output | 16 | Word read from the device |
| rx_push | output | 1 | Writes `rx_data` into the receive FIFO |
| rx_full | input | 1 | Receive FIFO cannot accept a word |
| dmack_n | output | 1 | DMA acknowledge, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_out | output | 16 | Data driven to the device bus |
| dd_in | input | 16 | Data sampled from the device bus |
| dd_oe | output | 1 | Output enable for `dd_out` |

## Verification
The bench targets the request-line window. It drops `dmarq` briefly just after a read trailing edge and restores it before the 30-cycle point. A sequencer that looks at the request too early would end after one word. Dropping `dmarq` for good after the first write word shows whether it ends one word later than it should, or never. It measures each release of the acknowledge from the trailing edge. A design that releases with the strobe would show zero cycles, and one that waits the full negated period would show 66. It also stops a read burst twice, once by terminal count and once by a full receive FIFO, and checks that the word count, pushed data and idle behaviour are right and that there is no restart while the FIFO stays full.

// File: rtl/atadma_pkg.sv
package atadma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACK  = 2'd1,
      ST_STRB = 2'd2,
      ST_NEG  = 2'd3
   } seq_st_e;

   // Round a time in ns up to whole clock cycles; non-zero times give at least one cycle.
   function automatic int ns2cyc(input int t_ns, input int clk_ns);
      int c;
      if (t_ns <= 0) return 0;
      c = (t_ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/atadma_timer.sv
module atadma_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   output logic [CW-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (rst || clr) cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/atadma_ctl.sv
module atadma_ctl
   import atadma_pkg::*;
#(
   parameter int CW     = 8,
   parameter int ACT_C  = 54,
   parameter int NEGR_C = 66,
   parameter int NEGW_C = 66,
   parameter int CHKR_C = 30,
   parameter int CHKW_C = 10
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          dmarq,
   input  logic          dir_wr,
   input  logic          term_cnt,
   input  logic          tx_valid,
   input  logic          rx_full,
   input  logic [CW-1:0] cnt,
   output seq_st_e       state,
   output logic          wr_q,
   output logic          tmr_clr,
   output logic          load_word,
   output logic          last_act
);

   seq_st_e       nxt;
   logic          wr_sel;
   logic          go;
   logic [CW-1:0] chk_at;
   logic [CW-1:0] neg_end;

   always_comb begin
      wr_sel    = (state == ST_IDLE) ? dir_wr : wr_q;
      go        = dmarq && !term_cnt && (wr_sel ? tx_valid : !rx_full);
      chk_at    = wr_q ? CW'(CHKW_C - 1) : CW'(CHKR_C - 1);
      neg_end   = wr_q ? CW'(NEGW_C - 1) : CW'(NEGR_C - 1);
      last_act  = (state == ST_STRB) && (cnt == CW'(ACT_C - 1));
      nxt       = state;
      tmr_clr   = 1'b0;
      load_word = 1'b0;
      case (state)
         ST_IDLE: begin
            tmr_clr = 1'b1;
            if (go) begin
               nxt       = ST_ACK;
               load_word = dir_wr;
            end
         end
         ST_ACK: begin
            nxt     = ST_STRB;
            tmr_clr = 1'b1;
         end
         ST_STRB: begin
            if (last_act) begin
               nxt     = ST_NEG;
               tmr_clr = 1'b1;
            end
         end
         ST_NEG: begin
            if (cnt == chk_at && !go) begin
               nxt = ST_IDLE;
            end else if (cnt == neg_end) begin
               nxt       = ST_STRB;
               tmr_clr   = 1'b1;
               load_word = wr_q;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         wr_q  <= 1'b0;
      end else begin
         state <= nxt;
         if (state == ST_IDLE && go) wr_q <= dir_wr;
      end
   end

endmodule

// File: rtl/atadma_dpath.sv
module atadma_dpath #(
   parameter int DW              = 16,
   parameter int CW              = 8,
   parameter int ACT_C           = 54,
   parameter int ACC_C           = 38,
   parameter bit SAMPLE_AT_TRAIL = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load_word,
   input  logic [DW-1:0] tx_data,
   input  logic          rd_strobe,
   input  logic [CW-1:0] cnt,
   input  logic [DW-1:0] dd_in,
   output logic [DW-1:0] dd_out,
   output logic [DW-1:0] rx_data,
   output logic          rx_push
);

   logic rd_last;
   assign rd_last = rd_strobe && (cnt == CW'(ACT_C - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         dd_out  <= '0;
         rx_push <= 1'b0;
      end else begin
         if (load_word) dd_out <= tx_data;
         rx_push <= rd_last;
      end
   end

   generate
      if (SAMPLE_AT_TRAIL) begin : g_cap_trail
         always_ff @(posedge clk) begin
            if (rst)          rx_data <= '0;
            else if (rd_last) rx_data <= dd_in;
         end
      end else begin : g_cap_access
         always_ff @(posedge clk) begin
            if (rst)                                       rx_data <= '0;
            else if (rd_strobe && cnt == CW'(ACC_C - 1))   rx_data <= dd_in;
         end
      end
   endgenerate

endmodule

// File: rtl/atadma_host.sv
module atadma_host
   import atadma_pkg::*;
#(
   parameter int DW              = 16,
   parameter int CLK_NS          = 4,
   parameter int CYCLE_NS        = 480,
   parameter int ACT_NS          = 215,
   parameter int NEG_RD_NS       = 50,
   parameter int NEG_WR_NS       = 215,
   parameter int ACK_HOLD_NS     = 20,
   parameter int WR_SETUP_NS     = 100,
   parameter int WR_HOLD_NS      = 20,
   parameter int RD_ACCESS_NS    = 150,
   parameter int RQ_RD_NS        = 120,
   parameter int RQ_WR_NS        = 40,
   parameter bit SAMPLE_AT_TRAIL = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          dmarq,
   input  logic          dir_wr,
   input  logic          term_cnt,
   input  logic [DW-1:0] tx_data,
   input  logic          tx_valid,
   output logic          tx_pop,
   output logic [DW-1:0] rx_data,
   output logic          rx_push,
   input  logic          rx_full,
   output logic          dmack_n,
   output logic          dior_n,
   output logic          diow_n,
   output logic [DW-1:0] dd_out,
   input  logic [DW-1:0] dd_in,
   output logic          dd_oe
);

   localparam int CYC_C  = ns2cyc(CYCLE_NS, CLK_NS);
   localparam int ACT_C  = ns2cyc(ACT_NS, CLK_NS);
   localparam int NEGR_C = imax(ns2cyc(NEG_RD_NS, CLK_NS), CYC_C - ACT_C);
   localparam int NEGW_C = imax(ns2cyc(NEG_WR_NS, CLK_NS), CYC_C - ACT_C);
   localparam int HOLD_C = ns2cyc(ACK_HOLD_NS, CLK_NS);
   localparam int WSU_C  = ns2cyc(WR_SETUP_NS, CLK_NS);
   localparam int WHD_C  = ns2cyc(WR_HOLD_NS, CLK_NS);
   localparam int ACC_C  = ns2cyc(RD_ACCESS_NS, CLK_NS);
   localparam int CHKR_C = imax(imax(ns2cyc(RQ_RD_NS, CLK_NS), HOLD_C), 1);
   localparam int CHKW_C = imax(imax(ns2cyc(RQ_WR_NS, CLK_NS), imax(HOLD_C, WHD_C)), 1);
   localparam int CW     = $clog2(imax(ACT_C, imax(NEGR_C, NEGW_C)) + 1);

   if (CLK_NS < 1) begin : g_bad_clk
      $error("atadma_host: CLK_NS must be positive");
   end
   if (ACT_C < 1 || ACC_C > ACT_C) begin : g_bad_acc
      $error("atadma_host: read access time exceeds strobe width");
   end
   if (WSU_C > ACT_C) begin : g_bad_wsu
      $error("atadma_host: write setup exceeds strobe width");
   end
   if (CHKR_C >= NEGR_C || CHKW_C >= NEGW_C) begin : g_bad_chk
      $error("atadma_host: request window must end inside negated phase");
   end

   seq_st_e       state;
   logic          wr_q;
   logic          tmr_clr;
   logic          load_word;
   logic          last_act;
   logic [CW-1:0] cnt;

   atadma_timer #(.CW(CW)) tmr_i (
      .clk (clk),
      .rst (rst),
      .clr (tmr_clr),
      .cnt (cnt)
   );

   atadma_ctl #(
      .CW     (CW),
      .ACT_C  (ACT_C),
      .NEGR_C (NEGR_C),
      .NEGW_C (NEGW_C),
      .CHKR_C (CHKR_C),
      .CHKW_C (CHKW_C)
   ) ctl_i (
      .clk       (clk),
      .rst       (rst),
      .dmarq     (dmarq),
      .dir_wr    (dir_wr),
      .term_cnt  (term_cnt),
      .tx_valid  (tx_valid),
      .rx_full   (rx_full),
      .cnt       (cnt),
      .state     (state),
      .wr_q      (wr_q),
      .tmr_clr   (tmr_clr),
      .load_word (load_word),
      .last_act  (last_act)
   );

   atadma_dpath #(
      .DW              (DW),
      .CW              (CW),
      .ACT_C           (ACT_C),
      .ACC_C           (ACC_C),
      .SAMPLE_AT_TRAIL (SAMPLE_AT_TRAIL)
   ) dp_i (
      .clk       (clk),
      .rst       (rst),
      .load_word (load_word),
      .tx_data   (tx_data),
      .rd_strobe ((state == ST_STRB) && !wr_q),
      .cnt       (cnt),
      .dd_in     (dd_in),
      .dd_out    (dd_out),
      .rx_data   (rx_data),
      .rx_push   (rx_push)
   );

   assign tx_pop  = load_word;
   assign dmack_n = (state == ST_IDLE);
   assign dior_n  = !((state == ST_STRB) && !wr_q);
   assign diow_n  = !((state == ST_STRB) && wr_q);
   assign dd_oe   = wr_q && (state != ST_IDLE);

endmodule

// File: rtl/atadma_host_chk.sv
module atadma_host_chk #(
   parameter int DW     = 16,
   parameter int ACT_C  = 54,
   parameter int HOLD_C = 5
) (
   input logic          clk,
   input logic          rst,
   input logic          dmack_n,
   input logic          dior_n,
   input logic          diow_n,
   input logic          dd_oe,
   input logic [DW-1:0] dd_out
);

   logic        strb;
   logic        strb_q;
   logic        ack_q;
   logic [15:0] act_len;
   logic [15:0] since_trail;

   assign strb = !dior_n || !diow_n;

   always_ff @(posedge clk) begin
      if (rst) begin
         strb_q      <= 1'b0;
         ack_q       <= 1'b1;
         act_len     <= '0;
         since_trail <= '0;
      end else begin
         strb_q      <= strb;
         ack_q       <= dmack_n;
         act_len     <= strb ? act_len + 16'd1 : 16'd0;
         since_trail <= strb ? 16'd0 : ((since_trail == 16'hFFFF) ? since_trail : since_trail + 16'd1);
      end
   end

   p_act_width_r2: assert property (@(posedge clk) disable iff (rst)
      (strb_q && !strb) |-> (act_len == 16'(ACT_C)));

   p_ack_cover_r5: assert property (@(posedge clk) disable iff (rst)
      strb |-> !dmack_n);

   p_ack_lead_r5: assert property (@(posedge clk) disable iff (rst)
      (strb && !strb_q) |-> !ack_q);

   p_ack_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (dmack_n && !ack_q) |-> (since_trail >= 16'(HOLD_C)));

   p_wdata_stable_r7: assert property (@(posedge clk) disable iff (rst)
      (!diow_n && $past(!diow_n)) |-> ($stable(dd_out) && dd_oe));

   p_no_oe_read_r11: assert property (@(posedge clk) disable iff (rst)
      !dior_n |-> !dd_oe);

   p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
      !(!dior_n && !diow_n));

endmodule

bind atadma_host atadma_host_chk #(
   .DW     (DW),
   .ACT_C  (ACT_C),
   .HOLD_C (HOLD_C)
) chk_i (
   .clk     (clk),
   .rst     (rst),
   .dmack_n (dmack_n),
   .dior_n  (dior_n),
   .diow_n  (diow_n),
   .dd_oe   (dd_oe),
   .dd_out  (dd_out)
);

// File: tb/atadma_host_tb_top.sv
`timescale 1ns/1ps
module atadma_host_tb_top;

   // Expected cycle counts at a 4 ns clock, from the requirements.
   localparam int E_ACT    = 54;
   localparam int E_NEG    = 66;
   localparam int E_PER    = 120;
   localparam int E_HOLD_R = 30;
   localparam int E_HOLD_W = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        dmarq = 1'b0;
   logic        dir_wr = 1'b0;
   logic        term_cnt = 1'b0;
   logic [15:0] tx_data;
   logic        tx_valid;
   logic        tx_pop;
   logic [15:0] rx_data;
   logic        rx_push;
   logic        rx_full;
   logic        dmack_n, dior_n, diow_n, dd_oe;
   logic [15:0] dd_out;
   logic [15:0] dd_in;

   int total = 0;
   int bad   = 0;

   // Local FIFO models
   logic [15:0] tx_mem [0:15];
   int tx_cnt = 0;
   int tx_rd  = 0;
   logic [15:0] rx_mem [0:15];
   int rx_n   = 0;
   int rx_cap = 16;

   // Device and bus monitor state
   int dev_idx = 0;
   int cyc = 0, words = 0, bursts = 0;
   int lead_n = 0, trail_n = 0, ack_fall_n = 0;
   bit have_lead = 0, have_trail = 0;
   int min_act, max_act, min_neg, max_neg, min_per, max_per;
   int setup_first = -1, hold_last = -1, oe_hold_last = -1, oe_in_read = 0;
   logic [15:0] wcap [0:15];
   bit ps = 0, p_wr = 0, pack = 1, poe = 0;
   logic [15:0] prev_dd = '0;

   always #2 clk = ~clk;

   assign tx_valid = (tx_rd < tx_cnt);
   assign tx_data  = tx_mem[tx_rd[3:0]];
   assign rx_full  = (rx_n >= rx_cap);
   assign dd_in    = 16'hA000 + 16'(dev_idx);

   atadma_host dut_i (
      .clk      (clk),
      .rst      (rst),
      .dmarq    (dmarq),
      .dir_wr   (dir_wr),
      .term_cnt (term_cnt),
      .tx_data  (tx_data),
      .tx_valid (tx_valid),
      .tx_pop   (tx_pop),
      .rx_data  (rx_data),
      .rx_push  (rx_push),
      .rx_full  (rx_full),
      .dmack_n  (dmack_n),
      .dior_n   (dior_n),
      .diow_n   (diow_n),
      .dd_out   (dd_out),
      .dd_in    (dd_in),
      .dd_oe    (dd_oe)
   );

   always @(posedge clk) begin
      if (tx_pop) tx_rd <= tx_rd + 1;
      if (rx_push) begin
         rx_mem[rx_n[3:0]] <= rx_data;
         rx_n <= rx_n + 1;
      end
   end

   always @(negedge clk) begin
      if (!rst) begin
         bit s;
         cyc = cyc + 1;
         s = !dior_n || !diow_n;
         if (s && !ps) begin
            if (have_lead) begin
               if (cyc - lead_n < min_per) min_per = cyc - lead_n;
               if (cyc - lead_n > max_per) max_per = cyc - lead_n;
            end
            if (have_trail) begin
               if (cyc - trail_n < min_neg) min_neg = cyc - trail_n;
               if (cyc - trail_n > max_neg) max_neg = cyc - trail_n;
            end else begin
               setup_first = cyc - ack_fall_n;
            end
            lead_n = cyc;
            have_lead = 1;
         end
         if (!s && ps) begin
            if (cyc - lead_n < min_act) min_act = cyc - lead_n;
            if (cyc - lead_n > max_act) max_act = cyc - lead_n;
            trail_n = cyc;
            have_trail = 1;
            if (p_wr) wcap[words[3:0]] = prev_dd;
            else      dev_idx = dev_idx + 1;
            words = words + 1;
         end
         if (!dmack_n && pack) ack_fall_n = cyc;
         if (dmack_n && !pack) begin
            hold_last = cyc - trail_n;
            bursts = bursts + 1;
            have_lead = 0;
            have_trail = 0;
         end
         if (!dd_oe && poe) oe_hold_last = cyc - trail_n;
         if (dd_oe && !dior_n) oe_in_read = oe_in_read + 1;
         ps = s; p_wr = !diow_n; pack = dmack_n; poe = dd_oe; prev_dd = dd_out;
      end
   end

   task automatic chk_eq(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_ge(input string req, input int act, input int lim);
      total++;
      if (act < lim) begin
         bad++;
         $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #0.5;
   endtask

   task automatic wait_words(input int n);
      int t = 0;
      while (words < n && t < 4000) begin tick(1); t++; end
      if (words < n) chk_eq("watchdog words", words, n);
   endtask

   task automatic wait_bursts(input int n);
      int t = 0;
      while (bursts < n && t < 4000) begin tick(1); t++; end
      if (bursts < n) chk_eq("watchdog bursts", bursts, n);
   endtask

   task automatic clr_stats();
      words = 0; bursts = 0; dev_idx = 0;
      have_lead = 0; have_trail = 0;
      min_act = 99999; max_act = 0; min_neg = 99999; max_neg = 0;
      min_per = 99999; max_per = 0;
      setup_first = -1; hold_last = -1; oe_hold_last = -1; oe_in_read = 0;
      rx_n = 0; tx_rd = 0; tx_cnt = 0;
   endtask

   task automatic t_reset();
      chk_eq("R1 dmack_n idle", int'(dmack_n), 1);
      chk_eq("R1 dior_n idle", int'(dior_n), 1);
      chk_eq("R1 diow_n idle", int'(diow_n), 1);
      chk_eq("R1 dd_oe idle", int'(dd_oe), 0);
   endtask

   task automatic t_no_start();
      clr_stats();
      tx_mem[0] = 16'h1234; tx_cnt = 1; dir_wr = 1;
      dmarq = 0;
      tick(40);
      chk_eq("R12 no ack without dmarq", int'(dmack_n), 1);
      term_cnt = 1; dmarq = 1;
      tick(40);
      chk_eq("R12 no ack with term_cnt", int'(dmack_n), 1);
      dmarq = 0; term_cnt = 0; dir_wr = 0; rx_cap = 0;
      dmarq = 1;
      tick(40);
      chk_eq("R12 no read start when rx full", int'(dmack_n), 1);
      dmarq = 0; rx_cap = 16;
      tick(4);
      chk_eq("R12 no burst counted", bursts, 0);
   endtask

   task automatic t_write_burst();
      clr_stats();
      tx_mem[0] = 16'h5A01; tx_mem[1] = 16'hC3C3; tx_mem[2] = 16'h0FF0;
      tx_cnt = 3; dir_wr = 1; dmarq = 1;
      wait_bursts(1);
      dmarq = 0;
      tick(4);
      chk_eq("R10 write ends on empty fifo", words, 3);
      chk_eq("R10 write pops", tx_rd, 3);
      chk_eq("R7 write word0", int'(wcap[0]), 'h5A01);
      chk_eq("R7 write word1", int'(wcap[1]), 'hC3C3);
      chk_eq("R7 write word2", int'(wcap[2]), 'h0FF0);
      chk_eq("R2 write min width", min_act, E_ACT);
      chk_eq("R2 write max width", max_act, E_ACT);
      chk_eq("R4 write negated width", min_neg, E_NEG);
      chk_ge("R4 write negated minimum", min_neg, 54);
      chk_eq("R3 write period", min_per, E_PER);
      chk_eq("R5 ack setup", setup_first, 1);
      chk_eq("R6 write ack hold", hold_last, E_HOLD_W);
      chk_ge("R7 write data hold", oe_hold_last, 5);
      chk_eq("R11 oe off after write", int'(dd_oe), 0);
   endtask

   task automatic t_read_term();
      clr_stats();
      dir_wr = 0; rx_cap = 16; dmarq = 1;
      wait_words(2);
      tick(1);
      term_cnt = 1;
      wait_bursts(1);
      dmarq = 0;
      tick(2);
      term_cnt = 0;
      chk_eq("R10 read ends on term_cnt", words, 2);
      chk_eq("R8 read pushes", rx_n, 2);
      chk_eq("R8 read word0", int'(rx_mem[0]), 'hA000);
      chk_eq("R8 read word1", int'(rx_mem[1]), 'hA001);
      chk_eq("R6 read ack hold", hold_last, E_HOLD_R);
      chk_eq("R4 read negated width", min_neg, E_NEG);
      chk_eq("R2 read width", max_act, E_ACT);
      chk_eq("R11 oe never during read", oe_in_read, 0);
   endtask

   task automatic t_read_full();
      clr_stats();
      dir_wr = 0; rx_cap = 2; dmarq = 1;
      wait_bursts(1);
      tick(200);
      chk_eq("R10 read ends on full fifo", words, 2);
      chk_eq("R10 no restart while full", bursts, 1);
      chk_eq("R10 ack idle while full", int'(dmack_n), 1);
      dmarq = 0;
      tick(2);
      rx_cap = 16;
   endtask

   task automatic t_read_glitch();
      clr_stats();
      dir_wr = 0; rx_cap = 16; dmarq = 1;
      wait_words(1);
      tick(2);
      dmarq = 0;
      tick(18);
      dmarq = 1;
      wait_words(2);
      tick(2);
      dmarq = 0;
      wait_bursts(1);
      tick(2);
      chk_eq("R9 early dmarq drop ignored", words, 2);
      chk_eq("R9 read ack release", hold_last, E_HOLD_R);
      chk_eq("R3 read period", max_per, E_PER);
   endtask

   task automatic t_write_drop();
      clr_stats();
      tx_mem[0] = 16'h1111; tx_mem[1] = 16'h2222; tx_mem[2] = 16'h3333; tx_mem[3] = 16'h4444;
      tx_cnt = 4; dir_wr = 1; dmarq = 1;
      wait_words(1);
      tick(2);
      dmarq = 0;
      wait_bursts(1);
      tick(2);
      chk_eq("R9 write stops on dmarq low", words, 1);
      chk_eq("R9 write pops one", tx_rd, 1);
      chk_eq("R6 write ack release", hold_last, E_HOLD_W);
      chk_eq("R7 word after drop", int'(wcap[0]), 'h1111);
   endtask

   initial begin
      fork
         begin
            tick(3);
            rst = 0;
            tick(2);
            t_reset();
            t_no_start();
            t_write_burst();
            t_read_term();
            t_read_full();
            t_read_glitch();
            t_write_drop();
         end
         begin
            repeat (150000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog expired actual=timeout expected=finish");
         end
      join_any
      disable fork;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule